// File: doc/BRIEF.md
# Run-End Flagger

A two-bit synchronous sequential circuit that watches a one-bit serial stream and raises its output during the cycle in which a zero follows one or more ones. Two D flip-flops, here named A (upper bit) and B (lower bit), hold the state. Their next values come from fixed sum-of-products equations, and the output is a Mealy function of the present state and the current input bit. So the flag is valid in the same cycle as the terminating zero, before the clock edge that samples it.

While ones keep arriving, the state first moves from 00 to 01, then to 11, then to 10, and it stays at 10 for as long as the ones continue. Any zero takes the machine back to 00. The state bits are brought out as a port so that a system can watch the run length in its coarse form: none, one, two, or three or more. The serial input is a plain level sampled on every rising edge, and there is no handshake.

Top module: `run_end_flagger`

## Requirements
- R1: A synchronous active-high `rst` forces the state {A,B} to 00 at the next rising edge, whatever `x` is.
- R2: When not in reset, the next A equals (A AND x) OR (B AND x).
- R3: When not in reset, the next B equals (NOT A) AND x.
- R4: `y` equals (NOT x) AND (A OR B), combinationally, in the same cycle as `x`.
- R5: From state 00 with `x`=0, the state stays 00 and `y` is 0. From 00 with `x`=1, the state goes to 01 and `y` is 0.
- R6: A run of ones from 00 visits 01, then 11, then 10, and stays at 10 while the ones last, with `y`=0 throughout.
- R7: A zero from state 01, 11 or 10 drives `y` to 1 in that cycle and returns the state to 00.
- R8: All eight combinations of present state and input give the next state and output listed in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial input bit, sampled every edge |
| y | output | 1 | Mealy flag: a zero that ends a run of ones |
| ab | output | 2 | Present state, bit 1 = A, bit 0 = B |

## Verification
State 11 is the hardest to reach. It lasts for exactly one cycle, and only after exactly two ones that follow a zero or a reset, so a stream of long runs passes through it without ever testing its zero exit. The stimulus puts the machine into 11 three times. It leaves once on a zero, once on a one, and once through a reset in the middle of a run. It also reaches 10 by way of 11 and holds it there with an extra one. In this way each of the eight state and input pairs is checked against a table kept in the bench.

// File: rtl/run_end_flagger_pkg.sv
package run_end_flagger_pkg;
  localparam int unsigned ST_W = 2;
  localparam int unsigned A_BIT = 1;
  localparam int unsigned B_BIT = 0;
  typedef logic [ST_W-1:0] st_t;
  localparam st_t ST_IDLE = 2'b00;
endpackage

// File: rtl/ref_next_state.sv
module ref_next_state
  import run_end_flagger_pkg::*;
(
  input  st_t  cur,
  input  logic x,
  output st_t  nxt
);
  logic a_q, b_q;
  assign a_q = cur[A_BIT];
  assign b_q = cur[B_BIT];
  always_comb begin
    nxt        = ST_IDLE;
    nxt[A_BIT] = (a_q & x) | (b_q & x);
    nxt[B_BIT] = ~a_q & x;
  end
endmodule

// File: rtl/ref_flag_out.sv
module ref_flag_out
  import run_end_flagger_pkg::*;
(
  input  st_t  cur,
  input  logic x,
  output logic y
);
  assign y = ~x & (cur[A_BIT] | cur[B_BIT]);
endmodule

// File: rtl/ref_state_reg.sv
module ref_state_reg
  import run_end_flagger_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_t  d,
  output st_t  q
);
  for (genvar i = 0; i < ST_W; i++) begin : g_dff
    always_ff @(posedge clk) begin
      if (rst) q[i] <= ST_IDLE[i];
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/run_end_flagger.sv
module run_end_flagger
  import run_end_flagger_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            x,
  output logic            y,
  output logic [ST_W-1:0] ab
);
  st_t cur_st, nxt_st;

  ref_next_state u_next (.cur(cur_st), .x(x), .nxt(nxt_st));
  ref_flag_out   u_out  (.cur(cur_st), .x(x), .y(y));
  ref_state_reg  u_reg  (.clk(clk), .rst(rst), .d(nxt_st), .q(cur_st));

  assign ab = cur_st;
endmodule

// File: rtl/run_end_flagger_chk.sv
module run_end_flagger_chk (
  input logic       clk,
  input logic       rst,
  input logic       x,
  input logic       y,
  input logic [1:0] ab
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> ab == 2'b00);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ab == 2'b00 && !x) |=> ab == 2'b00);
  p_idle_start_r5: assert property (@(posedge clk) disable iff (rst)
    (ab == 2'b00 && x) |=> ab == 2'b01);
  p_second_one_r6: assert property (@(posedge clk) disable iff (rst)
    (ab == 2'b01 && x) |=> ab == 2'b11);
  p_long_run_r2: assert property (@(posedge clk) disable iff (rst)
    (ab[1] && x) |=> ab == 2'b10);
  p_zero_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (ab != 2'b00 && !x) |=> ab == 2'b00);
  p_flag_cond_r4: assert property (@(posedge clk)
    y |-> (!x && ab != 2'b00));
  p_flag_due_r7: assert property (@(posedge clk)
    (!x && ab != 2'b00) |-> y);
endmodule

bind run_end_flagger run_end_flagger_chk u_chk (
  .clk(clk), .rst(rst), .x(x), .y(y), .ab(ab)
);

// File: tb/run_end_flagger_bench.sv
module run_end_flagger_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x   = 1'b0;
  logic       y;
  logic [1:0] ab;

  int checks = 0;
  int fails  = 0;
  logic [1:0] model_st = 2'b00;
  logic [2:0] expq[$];  // {y, next A, next B}
  bit done = 1'b0;

  always #5 clk = ~clk;

  run_end_flagger u_run_end_flagger (.clk(clk), .rst(rst), .x(x), .y(y), .ab(ab));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: applies a bit (and reset), pushes the expected flag and next state
  task automatic drive(input logic xv, input logic rv);
    logic ey;
    logic [1:0] en;
    @(negedge clk);
    x   = xv;
    rst = rv;
    ey = ~xv & (model_st != 2'b00);                          // R4, R7
    if (rv) en = 2'b00;                                      // R1
    else en = {(model_st[1] & xv) | (model_st[0] & xv),      // R2
               ~model_st[1] & xv};                           // R3
    expq.push_back({ey, en});
    model_st = en;
  endtask

  // Monitor: flag just after input settles, state just after the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expq.size() != 0) begin
        logic [2:0] e;
        e = expq.pop_front();
        check("R4/R7 y", int'(y), int'(e[2]));
        @(posedge clk);
        #1;
        check("R8 next state (R1 R2 R3 R5 R6)", int'(ab), int'(e[1:0]));
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", int'(ab), 0);
    @(negedge clk); rst = 1'b0; #2;
    check("R1 idle flag low", int'(y), 0);
    drive(0, 0);                              // R5 00/0 hold
    drive(1, 0);                              // R5 00/1 -> 01
    drive(0, 0);                              // R7 01/0 flag
    drive(1, 0); drive(1, 0);                 // R6 -> 11
    drive(0, 0);                              // R7 11/0 flag
    drive(1, 0); drive(1, 0); drive(1, 0);    // R6 11/1 -> 10
    drive(1, 0);                              // R6 10/1 hold
    drive(0, 0);                              // R7 10/0 flag
    drive(0, 0);
    drive(1, 0); drive(1, 0);                 // to 11
    drive(1, 1);                              // R1 reset wins over run
    drive(1, 0); drive(0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule